// File: doc/BRIEF.md
# Dual-Event Link Performance Counter

This block counts link events on two independent counters. A link controller supplies a wide vector of single-cycle event strobes. Each counter watches one strobe, chosen by its own event-select field. Each counter increments once in every cycle where its strobe is high and the counters are running. One shared control register drives both counters. It starts them, stops them, clears them and copies them into snapshot registers.

Software uses the block in a fixed sequence. It first writes the two event codes, for example code 40 for received messages and code 104 for posted requests sent. One control write with value 0x5 clears both counters and starts them. After the measurement window, a control write with value 0x2 stops counting and captures a coherent snapshot. The low word of each snapshot is read from that counter's own count register. The bits above the low word come back in lanes of the select register. Software rebuilds each full count as (upper << 32) | low.

The register interface is a plain write strobe with address and data, and a combinational read port. A write takes effect on the clock edge that samples it. Events in that same cycle are counted under the run state and selection that held before the write.

Top module: `perf_cnt_unit`

## Requirements
- R1: After a synchronous active-low reset, every readable register returns 0: the selects, the run bit, both snapshots and their upper lanes.
- R2: A write to address 0 sets counter 0's select from wdata[7:0] and counter 1's select from wdata[15:8]. The same address reads back select 0 in rdata[7:0] and select 1 in rdata[15:8]. Written bits 31:16 are ignored.
- R3: While running, counter i adds exactly 1 in each cycle where evt_strobe[select i] is high. Codes 40 and 104 are valid selects. A strobe at any index that is not selected adds nothing.
- R4: A control write (address 1) with bit 0 set starts both counters, and one with bit 0 clear stops them. A stopped counter holds its value. Address 1 reads the run state in bit 0, with all other bits 0.
- R5: A control write with bit 2 set clears both live counters to zero at that edge. Value 0x5 therefore clears and starts both counters together.
- R6: A control write with bit 1 set copies both live counters into their snapshots. Address 2 reads snapshot 0 and address 3 reads snapshot 1, as the low LOW_W bits zero-extended. Neither address returns a live value.
- R7: Address 0 returns the snapshot bits above LOW_W: counter 0 in rdata[16 +: HI_W] and counter 1 in rdata[24 +: HI_W].
- R8: Each counter is LOW_W+HI_W bits wide (40 by default). It wraps from all ones to zero without saturating, and carries from the low word into the upper field.
- R9: A control write with both bit 1 and bit 2 set captures the values the counters held before the clear.
- R10: Strobes in the cycle of a control write count under the old run state. A start write does not count that cycle's strobe, and a stop write does.
- R11: Writes to addresses 2 and 3 have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_strobe | input | 2**EVT_W | Single-cycle event strobes from the link controller |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 select, 1 control, 2 count 0, 3 count 1) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |

## Verification
The bench keeps its own model of the live counts, snapshots, selects and run state, and compares the read port against it every cycle. Most faults inside the block stay hidden until the next snapshot, because the counts are seen only through the shadow registers. A wrong increment, a missed clear or a bad select shows up on the first read after the next bit-1 control write. A corrupted select or run bit shows up on the very next read of address 0 or 1. The bench uses a narrow counter configuration so that the wrap and the carry into the upper lane happen within a short run.

// File: rtl/perf_cnt_pkg.sv
// Shared constants for the dual-event performance counter.
// Assumes a 32-bit register bus with four word addresses.
package perf_cnt_pkg;
    localparam int NUM_CNT   = 2;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 2;
    localparam int LANE_W    = 8;
    localparam int UPPER_LSB = 16;
    localparam int CTL_RUN   = 0;
    localparam int CTL_SNAP  = 1;
    localparam int CTL_CLR   = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_SELECT  = 2'd0,
        REG_CONTROL = 2'd1,
        REG_COUNT0  = 2'd2,
        REG_COUNT1  = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/perf_evt_pick.sv
// Picks one strobe out of the event vector by index.
// Assumes the vector holds one entry for every possible index value.
module perf_evt_pick #(
    parameter int EVT_W = 8,
    localparam int NUM_EVT = 1 << EVT_W
) (
    input  logic [NUM_EVT-1:0] strobe,
    input  logic [EVT_W-1:0]   sel,
    output logic               hit
);
    // Index the strobe vector with the programmed select.
    always_comb hit = strobe[sel];
endmodule

// File: rtl/perf_cnt_slice.sv
// One live counter with its snapshot register.
// A clear has priority over an increment. A snapshot always captures the
// value from before this edge, so a clear and a snapshot can share a write.
module perf_cnt_slice #(
    parameter int CNT_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             hit,
    input  logic             clr,
    input  logic             snap,
    output logic [CNT_W-1:0] live,
    output logic [CNT_W-1:0] shadow
);
    // Live count: clear, or add one on a selected strobe while running.
    always_ff @(posedge clk) begin
        if (!rst_n)
            live <= '0;
        else if (clr)
            live <= '0;
        else if (run && hit)
            live <= live + CNT_W'(1);
    end

    // Snapshot: copy the value from before this edge when asked.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow <= '0;
        else if (snap)
            shadow <= live;
    end
endmodule

// File: rtl/perf_cnt_regs.sv
// Register interface: select fields, run bit, control pulse decode and
// the read multiplexer. Assumes EVT_W <= 8, HI_W <= 8 and LOW_W <= 32.
module perf_cnt_regs
    import perf_cnt_pkg::*;
#(
    parameter int EVT_W = 8,
    parameter int LOW_W = 32,
    parameter int HI_W  = 8,
    localparam int CNT_W = LOW_W + HI_W
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [DATA_W-1:0]               wdata,
    input  logic [NUM_CNT-1:0][CNT_W-1:0]   shadow,
    output logic [NUM_CNT-1:0][EVT_W-1:0]   sel,
    output logic                            run,
    output logic                            clr,
    output logic                            snap,
    output logic [DATA_W-1:0]               rdata
);
    logic ctrl_wr;

    // Decode a control write.
    always_comb ctrl_wr = wr_en && (reg_addr_e'(addr) == REG_CONTROL);

    // Clear and snapshot act only at the edge that samples the write.
    always_comb begin
        clr  = ctrl_wr && wdata[CTL_CLR];
        snap = ctrl_wr && wdata[CTL_SNAP];
    end

    // Select fields and the run bit, written by the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel <= '0;
            run <= 1'b0;
        end else if (wr_en) begin
            if (reg_addr_e'(addr) == REG_SELECT) begin
                for (int i = 0; i < NUM_CNT; i++)
                    sel[i] <= wdata[i*LANE_W +: EVT_W];
            end
            if (reg_addr_e'(addr) == REG_CONTROL)
                run <= wdata[CTL_RUN];
        end
    end

    // Read multiplexer: counts come only from the snapshots.
    always_comb begin
        rdata = '0;
        case (reg_addr_e'(addr))
            REG_SELECT: begin
                for (int i = 0; i < NUM_CNT; i++) begin
                    rdata[i*LANE_W +: EVT_W] = sel[i];
                    rdata[UPPER_LSB + i*LANE_W +: HI_W] = shadow[i][CNT_W-1:LOW_W];
                end
            end
            REG_CONTROL: rdata[CTL_RUN] = run;
            REG_COUNT0:  rdata[LOW_W-1:0] = shadow[0][LOW_W-1:0];
            REG_COUNT1:  rdata[LOW_W-1:0] = shadow[1][LOW_W-1:0];
            default:     rdata = '0;
        endcase
    end
endmodule

// File: rtl/perf_cnt_unit.sv
// Dual-event performance counter top.
// Wires the register block to one pick/slice pair per counter.
// Assumes that strobes are single-cycle and synchronous to clk.
module perf_cnt_unit
    import perf_cnt_pkg::*;
#(
    parameter int EVT_W = 8,
    parameter int LOW_W = 32,
    parameter int HI_W  = 8,
    localparam int CNT_W   = LOW_W + HI_W,
    localparam int NUM_EVT = 1 << EVT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_strobe,
    input  logic               wr_en,
    input  logic [1:0]         addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata
);
    logic [NUM_CNT-1:0][EVT_W-1:0] sel;
    logic [NUM_CNT-1:0][CNT_W-1:0] live_cnt;
    logic [NUM_CNT-1:0][CNT_W-1:0] shadow_cnt;
    logic [NUM_CNT-1:0]            hit;
    logic                          run_q;
    logic                          clr;
    logic                          snap;

    perf_cnt_regs #(.EVT_W(EVT_W), .LOW_W(LOW_W), .HI_W(HI_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .shadow (shadow_cnt),
        .sel    (sel),
        .run    (run_q),
        .clr    (clr),
        .snap   (snap),
        .rdata  (rdata)
    );

    // One event pick and one counter slice per counter.
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        perf_evt_pick #(.EVT_W(EVT_W)) u_pick (
            .strobe (evt_strobe),
            .sel    (sel[g]),
            .hit    (hit[g])
        );
        perf_cnt_slice #(.CNT_W(CNT_W)) u_slice (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (run_q),
            .hit    (hit[g]),
            .clr    (clr),
            .snap   (snap),
            .live   (live_cnt[g]),
            .shadow (shadow_cnt[g])
        );
    end
endmodule

// File: rtl/perf_cnt_chk.sv
// Checker for perf_cnt_unit: relates control writes, strobes and the live
// and snapshot counters over time. Attached by bind below.
module perf_cnt_chk
    import perf_cnt_pkg::*;
#(
    parameter int CNT_W = 40
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [1:0]                    addr,
    input  logic [2:0]                    ctl,
    input  logic                          run,
    input  logic [NUM_CNT-1:0]            hit,
    input  logic [NUM_CNT-1:0][CNT_W-1:0] live,
    input  logic [NUM_CNT-1:0][CNT_W-1:0] shadow
);
    logic ctrl_wr;
    always_comb ctrl_wr = wr_en && (addr == 2'd1);

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
        // R5
        clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_wr && ctl[CTL_CLR]) |=> (live[i] == '0));
        // R6
        snap_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_wr && ctl[CTL_SNAP]) |=> (shadow[i] == $past(live[i])));
        // R11
        shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(ctrl_wr && ctl[CTL_SNAP]) |=> $stable(shadow[i]));
        // R4
        stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!run && !ctrl_wr) |=> $stable(live[i]));
        // R3
        step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (run && hit[i] && !ctrl_wr) |=> (live[i] == CNT_W'($past(live[i]) + 1'b1)));
        // R8
        wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (run && hit[i] && !ctrl_wr && (&live[i])) |=> (live[i] == '0));
    end
endmodule

bind perf_cnt_unit perf_cnt_chk #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .ctl    (wdata[2:0]),
    .run    (run_q),
    .hit    (hit),
    .live   (live_cnt),
    .shadow (shadow_cnt)
);

// File: tb/perf_cnt_unit_test.sv
// Bench: a behavioural reference model, compared with the read port every clock.
module perf_cnt_unit_test;
    localparam int LW = 8;
    localparam int HW = 4;
    localparam longint MASK = (64'd1 << (LW + HW)) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [255:0] evt = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    longint m_live [2];
    longint m_shad [2];
    int     m_sel [2];
    bit     m_run;
    string  prev_tag = "R1";

    always #2.5 clk = ~clk;

    perf_cnt_unit #(.EVT_W(8), .LOW_W(LW), .HI_W(HW)) uut (
        .clk(clk), .rst_n(rst_n), .evt_strobe(evt), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    function automatic logic [31:0] model_read(input logic [1:0] a);
        longint lo_mask = (64'd1 << LW) - 1;
        case (a)
            2'd0: return 32'(((m_shad[1] >> LW) << 24) | ((m_shad[0] >> LW) << 16)
                             | (m_sel[1] << 8) | m_sel[0]);
            2'd1: return {31'd0, m_run};
            2'd2: return 32'(m_shad[0] & lo_mask);
            default: return 32'(m_shad[1] & lo_mask);
        endcase
    endfunction

    // Compare the current read, then drive one cycle and advance the model.
    task automatic step(input bit w, input logic [1:0] a, input logic [31:0] d,
                        input int e0, input int e1, input string tag);
        logic [31:0] exp_v;
        bit hit [2];
        @(negedge clk);
        exp_v = model_read(addr);
        vectors++;
        if (rdata !== exp_v) begin
            miscompares++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", prev_tag, addr, rdata, exp_v);
        end
        wr_en = w; addr = a; wdata = d;
        evt = '0;
        if (e0 >= 0) evt[e0] = 1'b1;
        if (e1 >= 0) evt[e1] = 1'b1;
        prev_tag = tag;
        @(posedge clk);
        for (int i = 0; i < 2; i++)
            hit[i] = (e0 == m_sel[i]) || (e1 == m_sel[i]);
        if (w && a == 2'd1 && d[1]) begin
            m_shad[0] = m_live[0]; m_shad[1] = m_live[1];
        end
        for (int i = 0; i < 2; i++) begin
            if (w && a == 2'd1 && d[2]) m_live[i] = 0;
            else if (m_run && hit[i]) m_live[i] = (m_live[i] + 1) & MASK;
        end
        if (w && a == 2'd1) m_run = d[0];
        if (w && a == 2'd0) begin
            m_sel[0] = int'(d[7:0]); m_sel[1] = int'(d[15:8]);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 2; i++) begin m_live[i] = 0; m_shad[i] = 0; m_sel[i] = 0; end
        m_run = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: every register reads zero out of reset
        for (int a = 0; a < 4; a++) step(0, 2'(a), 0, -1, -1, "R1");
        // R2: program codes 40 and 104; the upper written bits are ignored
        step(1, 2'd0, 32'hFFFF_6828, -1, -1, "R2");
        step(0, 2'd0, 0, 40, 104, "R2");
        // R5 R10: clear and start; this cycle's strobes count under the old stopped state
        step(1, 2'd1, 32'h5, 40, 104, "R10");
        // R3: several strobe patterns, including unselected index 7
        for (int c = 0; c < 40; c++)
            step(0, 2'(c % 2), 0, (c % 3 != 0) ? 40 : 7, (c % 2 == 0) ? 104 : 7, "R3");
        // R6 R10: stop and capture; this cycle's strobes still count
        step(1, 2'd1, 32'h2, 40, 104, "R10");
        for (int a = 0; a < 4; a++) step(0, 2'(a), 0, 40, 104, "R6");
        // R11: writes to the count registers change nothing
        step(1, 2'd2, 32'hFFFF_FFFF, -1, -1, "R11");
        step(1, 2'd3, 32'hFFFF_FFFF, -1, 104, "R11");
        for (int a = 0; a < 4; a++) step(0, 2'(a), 0, -1, -1, "R11");
        // R4: restart without clearing; the snapshot stays, live keeps counting
        step(1, 2'd1, 32'h1, -1, -1, "R4");
        for (int c = 0; c < 20; c++) step(0, 2'((c % 3) + 1), 0, 40, -1, "R6");
        // R9: clear and snapshot in one write capture the pre-clear values
        step(1, 2'd1, 32'h7, 40, 104, "R9");
        for (int a = 0; a < 4; a++) step(0, 2'(a), 0, 40, 104, "R9");
        // R8 R7: select index 5, run past the low-word carry and the full wrap
        step(1, 2'd0, 32'h0000_0305, -1, -1, "R2");
        step(1, 2'd1, 32'h5, -1, -1, "R5");
        for (int c = 0; c < 4400; c++) begin
            if (c % 500 == 499) step(1, 2'd1, 32'h3, 5, 3, "R7");
            else step(0, 2'(c % 4), 0, 5, (c % 2 == 0) ? 3 : -1, "R8");
        end
        // R4: stop, strobes must not count, then capture
        step(1, 2'd1, 32'h0, 5, 3, "R4");
        for (int c = 0; c < 10; c++) step(0, 2'(c % 4), 0, 5, 3, "R4");
        step(1, 2'd1, 32'h2, 5, 3, "R4");
        for (int a = 0; a < 4; a++) step(0, 2'(a), 0, -1, -1, "R4");
        finished = 1'b1;
        finish_run();
    end

    // Watchdog: a hung run is reported as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end
endmodule